// File: doc/BRIEF.md
# Synchronous Multiplexed PSRAM Burst Writer

This block is a bus master that writes bursts of 16-bit half-words into a pseudo-static RAM over a shared address/data bus, using a memory clock it derives from the system clock. A request carries a 26-bit half-word address and a beat count. The write data then streams in through a valid/ready port, and the block fetches each half-word just before it is due on the bus.

Each access begins with one memory-clock period in which the low sixteen address bits sit on the shared bus and the address strobe is low. The upper ten bits go on separate pins. After a programmable latency the block places one half-word per memory clock on the bus. A wait input from the memory can hold the current half-word for extra periods. Its active level is programmable. Once the last half-word has gone out, chip enable stays high for a programmable gap before the next access can start.

Every bus output changes only at a falling edge of the memory clock, so the memory samples stable values on the rising edge.

Top module: `psram_burst_wr`

## Requirements
- R1: In the first memory-clock period of an access (the address period), `mem_adv_no`, `mem_ce_no` and `mem_we_no` are low and `{mem_a_hi_o, mem_ad_o}` equals `req_addr_i`. `mem_a_hi_o` holds this value for as long as chip enable stays low.
- R2: Number the address period as period 0. The first half-word appears on `mem_ad_o` in period `lat_i`. A `lat_i` value below 2 is handled as 2.
- R3: A burst places `req_len_i` half-words on the bus, in the order they were fetched, at one per memory-clock period when no wait is active. Chip enable rises at the end of the last period.
- R4: At the end of each data period the wait input is taken as active when `mem_wait_i == wait_pol_i` (1 means active high, 0 means active low). When it is active, the current half-word stays on the bus for one more period. Wait has no effect in the address period or in the latency periods.
- R5: `mem_oe_no` stays high at all times.
- R6: `mem_ad_oe_o` is high exactly while `mem_ce_no` is low.
- R7: After a burst, chip enable stays high for at least `gap_i`+1 memory-clock periods before the next address period begins. A `gap_i` of 0 is handled as 1.
- R8: The memory clock has a period of `clk_div_i` system clocks (values below 2 are handled as 2). It is high for `clk_div_i - floor(clk_div_i/2)` cycles of that period. `mem_ce_no`, `mem_adv_no` and `mem_we_no` change only when the memory clock falls.
- R9: `wdata_ready_o` is low during the address period. A burst takes exactly `req_len_i` words from the write-data port.
- R10: When chip enable rises at the end of a burst, `done_o` pulses high for one system clock. `req_ready_o` stays low from acceptance until the gap has elapsed.
- R11: During and after reset, chip enable, address strobe, write enable and output enable are high, `mem_ad_oe_o` and `done_o` are low, and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_div_i | input | 4 | Memory clock divide ratio |
| lat_i | input | 4 | Periods from the address period to the first half-word |
| gap_i | input | 4 | Minimum chip-enable-high gap, in memory-clock periods |
| wait_pol_i | input | 1 | Active level of the wait input |
| req_valid_i | input | 1 | Burst request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_addr_i | input | 26 | Half-word start address |
| req_len_i | input | 8 | Number of half-words in the burst |
| wdata_i | input | 16 | Write data |
| wdata_valid_i | input | 1 | Write data valid |
| wdata_ready_o | output | 1 | Write data taken when high with valid |
| done_o | output | 1 | One-cycle pulse at the end of a burst |
| mem_clk_o | output | 1 | Memory clock |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_adv_no | output | 1 | Address valid strobe, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low (held high) |
| mem_a_hi_o | output | 10 | Upper address bits [25:16] |
| mem_ad_o | output | 16 | Shared address/data bus, output value |
| mem_ad_oe_o | output | 1 | Drive enable for the shared bus |
| mem_wait_i | input | 1 | Wait from the memory |

## Verification
The properties assume that `clk_div_i`, `lat_i`, `gap_i` and `wait_pol_i` stay constant from acceptance until chip enable has been high for the gap. The gap property reads `gap_i` live at the next falling edge of chip enable. The properties also assume that write data is offered while the fetch window is open, so every issued half-word is a fresh one. The stimulus keeps `wdata_valid_i` high throughout and changes the configuration only while the block is idle, after at least eight idle memory periods. Back-to-back bursts are issued only with an unchanged configuration.

// File: rtl/psram_wr_pkg.sv
package psram_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_ADDR,
    ST_LAT,
    ST_DATA,
    ST_GAP
  } wr_state_e;
endpackage

// File: rtl/psram_clk_div.sv
module psram_clk_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             mem_clk_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, div_eff, half;
  logic             clk_q;

  assign div_eff = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
  assign half    = div_eff >> 1;
  // tick marks the system edge on which the memory clock falls
  assign tick_o  = (cnt_q >= div_eff - DIV_W'(1));
  assign cnt_d   = tick_o ? '0 : cnt_q + DIV_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= (cnt_d >= half);
    end
  end

  assign mem_clk_o = clk_q;
endmodule

// File: rtl/psram_wbuf.sv
module psram_wbuf #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic [DATA_W-1:0] dout_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (push_i) begin
      full_q <= 1'b1;
      data_q <= din_i;
    end else if (pop_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign dout_o = data_q;
endmodule

// File: rtl/psram_wr_fsm.sv
module psram_wr_fsm
  import psram_wr_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  parameter int LAT_W  = 4,
  parameter int GAP_W  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [LEN_W-1:0]         req_len_i,
  input  logic [LAT_W-1:0]         lat_i,
  input  logic [GAP_W-1:0]         gap_i,
  input  logic                     wait_act_i,
  input  logic                     push_i,
  input  logic                     buf_full_i,
  input  logic [DATA_W-1:0]        buf_data_i,
  output logic                     buf_pop_o,
  output logic                     fetch_en_o,
  output logic                     ce_no,
  output logic                     adv_no,
  output logic                     we_no,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] a_hi_o,
  output logic                     done_o
);
  localparam int CNT_W = (LAT_W > GAP_W) ? LAT_W : GAP_W;

  wr_state_e                state_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [LEN_W-1:0]         beats_q, fetch_q, len_eff;
  logic [LAT_W-1:0]         lat_q, lat_eff;
  logic [GAP_W-1:0]         gap_q, gap_eff;
  logic [CNT_W-1:0]         cnt_q;
  logic                     ce_q, adv_q, we_q, oe_q, done_q;
  logic [DATA_W-1:0]        ad_q;
  logic [ADDR_W-DATA_W-1:0] a_hi_q;
  logic                     lat_last, issue;

  assign len_eff  = (req_len_i == '0) ? LEN_W'(1) : req_len_i;
  assign lat_eff  = (lat_i < LAT_W'(2)) ? LAT_W'(2) : lat_i;
  assign gap_eff  = (gap_i == '0) ? GAP_W'(1) : gap_i;
  assign lat_last = (state_q == ST_LAT) && (cnt_q == CNT_W'(1));
  // a beat leaves the holding register on the tick that starts its period
  assign issue    = tick_i && (lat_last ||
                    (state_q == ST_DATA && !wait_act_i && beats_q != '0));

  assign req_ready_o = (state_q == ST_IDLE);
  assign buf_pop_o   = issue;
  assign fetch_en_o  = (lat_last || state_q == ST_DATA) &&
                       (fetch_q != '0) && !buf_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      beats_q <= '0;
      fetch_q <= '0;
      lat_q   <= '0;
      gap_q   <= '0;
      cnt_q   <= '0;
      ce_q    <= 1'b1;
      adv_q   <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b0;
      ad_q    <= '0;
      a_hi_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (push_i) fetch_q <= fetch_q - LEN_W'(1);
      if (issue) begin
        ad_q    <= buf_data_i;
        beats_q <= beats_q - LEN_W'(1);
      end
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          beats_q <= len_eff;
          fetch_q <= len_eff;
          lat_q   <= lat_eff;
          gap_q   <= gap_eff;
          state_q <= ST_PEND;
        end
        ST_PEND: if (tick_i) begin
          ce_q    <= 1'b0;
          adv_q   <= 1'b0;
          we_q    <= 1'b0;
          oe_q    <= 1'b1;
          ad_q    <= addr_q[DATA_W-1:0];
          a_hi_q  <= addr_q[ADDR_W-1:DATA_W];
          state_q <= ST_ADDR;
        end
        ST_ADDR: if (tick_i) begin
          adv_q   <= 1'b1;
          cnt_q   <= CNT_W'(lat_q) - CNT_W'(1);
          state_q <= ST_LAT;
        end
        ST_LAT: if (tick_i) begin
          if (lat_last) state_q <= ST_DATA;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        end
        ST_DATA: if (tick_i && !wait_act_i && beats_q == '0) begin
          ce_q    <= 1'b1;
          we_q    <= 1'b1;
          oe_q    <= 1'b0;
          ad_q    <= '0;
          done_q  <= 1'b1;
          cnt_q   <= CNT_W'(gap_q);
          state_q <= ST_GAP;
        end
        ST_GAP: if (tick_i) begin
          if (cnt_q == CNT_W'(1)) state_q <= ST_IDLE;
          else                    cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ce_no   = ce_q;
  assign adv_no  = adv_q;
  assign we_no   = we_q;
  assign ad_o    = ad_q;
  assign ad_oe_o = oe_q;
  assign a_hi_o  = a_hi_q;
  assign done_o  = done_q;
endmodule

// File: rtl/psram_burst_wr.sv
module psram_burst_wr #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8,
  parameter int DIV_W  = 4,
  parameter int LAT_W  = 4,
  parameter int GAP_W  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DIV_W-1:0]         clk_div_i,
  input  logic [LAT_W-1:0]         lat_i,
  input  logic [GAP_W-1:0]         gap_i,
  input  logic                     wait_pol_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [LEN_W-1:0]         req_len_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     wdata_valid_i,
  output logic                     wdata_ready_o,
  output logic                     done_o,
  output logic                     mem_clk_o,
  output logic                     mem_ce_no,
  output logic                     mem_adv_no,
  output logic                     mem_we_no,
  output logic                     mem_oe_no,
  output logic [ADDR_W-DATA_W-1:0] mem_a_hi_o,
  output logic [DATA_W-1:0]        mem_ad_o,
  output logic                     mem_ad_oe_o,
  input  logic                     mem_wait_i
);
  logic              tick, wait_act, push, pop, buf_full, fetch_en;
  logic [DATA_W-1:0] buf_data;

  assign wait_act      = (mem_wait_i == wait_pol_i);
  assign push          = fetch_en & wdata_valid_i;
  assign wdata_ready_o = fetch_en;
  assign mem_oe_no     = 1'b1;

  psram_clk_div #(.DIV_W(DIV_W)) i_clk_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (clk_div_i),
    .mem_clk_o (mem_clk_o),
    .tick_o    (tick)
  );

  psram_wbuf #(.DATA_W(DATA_W)) i_wbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .din_i  (wdata_i),
    .pop_i  (pop),
    .full_o (buf_full),
    .dout_o (buf_data)
  );

  psram_wr_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .LAT_W  (LAT_W),
    .GAP_W  (GAP_W)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_len_i   (req_len_i),
    .lat_i       (lat_i),
    .gap_i       (gap_i),
    .wait_act_i  (wait_act),
    .push_i      (push),
    .buf_full_i  (buf_full),
    .buf_data_i  (buf_data),
    .buf_pop_o   (pop),
    .fetch_en_o  (fetch_en),
    .ce_no       (mem_ce_no),
    .adv_no      (mem_adv_no),
    .we_no       (mem_we_no),
    .ad_o        (mem_ad_o),
    .ad_oe_o     (mem_ad_oe_o),
    .a_hi_o      (mem_a_hi_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/psram_wr_chk.sv
module psram_wr_chk #(
  parameter int AHI_W = 10,
  parameter int GAP_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mem_clk_o,
  input logic             mem_ce_no,
  input logic             mem_adv_no,
  input logic             mem_we_no,
  input logic             mem_oe_no,
  input logic             mem_ad_oe_o,
  input logic [AHI_W-1:0] mem_a_hi_o,
  input logic             req_ready_o,
  input logic             wdata_ready_o,
  input logic             done_o,
  input logic [GAP_W-1:0] gap_i
);
  localparam int HC_W = GAP_W + 2;

  logic [HC_W-1:0] hi_cnt;
  logic            mclk_d;
  logic [HC_W-1:0] gap_need;

  assign gap_need = (gap_i == '0) ? HC_W'(2) : HC_W'(gap_i) + HC_W'(1);

  // memory-clock rising edges seen while chip enable is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '1;
      mclk_d <= 1'b0;
    end else begin
      mclk_d <= mem_clk_o;
      if (!mem_ce_no) hi_cnt <= '0;
      else if (mem_clk_o && !mclk_d && hi_cnt != '1) hi_cnt <= hi_cnt + HC_W'(1);
    end
  end

  // R1
  addr_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_adv_no |-> (!mem_ce_no && !mem_we_no));
  // R1
  a_hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_a_hi_o));
  // R5
  oe_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_oe_no);
  // R6
  bus_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ad_oe_o == !mem_ce_no);
  // R7
  ce_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> (hi_cnt >= gap_need));
  // R8
  edge_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({mem_ce_no, mem_adv_no, mem_we_no}) |-> $fell(mem_clk_o));
  // R9
  no_fetch_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_adv_no |-> !wdata_ready_o);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  done_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($rose(mem_ce_no) && !req_ready_o));
  // R10
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> mem_ce_no);
endmodule

bind psram_burst_wr psram_wr_chk #(
  .AHI_W (ADDR_W - DATA_W),
  .GAP_W (GAP_W)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mem_clk_o     (mem_clk_o),
  .mem_ce_no     (mem_ce_no),
  .mem_adv_no    (mem_adv_no),
  .mem_we_no     (mem_we_no),
  .mem_oe_no     (mem_oe_no),
  .mem_ad_oe_o   (mem_ad_oe_o),
  .mem_a_hi_o    (mem_a_hi_o),
  .req_ready_o   (req_ready_o),
  .wdata_ready_o (wdata_ready_o),
  .done_o        (done_o),
  .gap_i         (gap_i)
);

// File: tb/test_psram_burst_wr.sv
`timescale 1ns/1ps
module test_psram_burst_wr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  div = 4'd2, lat = 4'd2, gap = 4'd1;
  logic        pol = 1'b1;
  logic        req_valid = 1'b0;
  logic [25:0] req_addr = '0;
  logic [7:0]  req_len = 8'd1;
  logic [15:0] wdata;
  logic        wvalid = 1'b1;
  logic        mem_wait = 1'b0;
  logic        req_ready, wready, done, mem_clk, ce_n, adv_n, we_n, oe_n, ad_oe;
  logic [9:0]  a_hi;
  logic [15:0] ad;

  always #2.5 clk = ~clk;

  psram_burst_wr i_psram_burst_wr (
    .clk_i(clk), .rst_ni(rst_n), .clk_div_i(div), .lat_i(lat), .gap_i(gap),
    .wait_pol_i(pol), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .wdata_i(wdata),
    .wdata_valid_i(wvalid), .wdata_ready_o(wready), .done_o(done),
    .mem_clk_o(mem_clk), .mem_ce_no(ce_n), .mem_adv_no(adv_n), .mem_we_no(we_n),
    .mem_oe_no(oe_n), .mem_a_hi_o(a_hi), .mem_ad_o(ad), .mem_ad_oe_o(ad_oe),
    .mem_wait_i(mem_wait)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'hA000 ^ 16'(i * 311);
  endfunction

  // write-data source
  int src_idx = 0;
  assign wdata = pat(src_idx);
  always @(posedge clk) if (wvalid && wready) src_idx <= src_idx + 1;

  // memory model, samples on memory-clock rising edges
  logic [25:0] cap_addr = '0;
  logic [15:0] got [0:63];
  int n_got = 0, per_idx = 0, cur_lat = 2;
  int hi_edges = 1000, last_gap = 0, bus_bad = 0, we_bad = 0;
  logic ce_prev = 1'b1;
  always @(posedge mem_clk) begin
    if (!ce_n) begin
      if (ce_prev) last_gap = hi_edges;
      hi_edges = 0;
      if (we_n) we_bad++;
      if (!ad_oe) bus_bad++;
      if (!adv_n) begin
        cap_addr = {a_hi, ad};
        per_idx = 0;
      end else begin
        per_idx++;
        if (per_idx >= cur_lat && mem_wait !== pol && n_got < 64) begin
          got[n_got] = ad;
          n_got++;
        end
      end
    end else begin
      hi_edges++;
      if (ad_oe) bus_bad++;
    end
    ce_prev = ce_n;
  end

  // wait driver, indexed by period number counted from the address period
  logic [31:0] wait_mask = '0;
  int drv_idx = 0;
  always @(negedge mem_clk) begin
    #1;
    if (!adv_n) drv_idx = 0;
    else if (!ce_n) drv_idx++;
    if (!ce_n && drv_idx < 32 && wait_mask[drv_idx]) mem_wait = pol;
    else mem_wait = ~pol;
  end

  int adv_push = 0, done_cnt = 0, ready_bad = 0, oe_bad = 0;
  always @(posedge clk) begin
    if (!adv_n && wvalid && wready) adv_push++;
    if (done) begin
      done_cnt++;
      if (req_ready) ready_bad++;
    end
    if (rst_n && !oe_n) oe_bad++;
  end

  task automatic issue(input logic [25:0] a, input logic [7:0] n);
    @(negedge clk);
    req_addr = a;
    req_len = n;
    req_valid = 1'b1;
    do @(posedge clk); while (!req_ready);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end(input string tag);
    int t = 0;
    while (!done && t < 4000) begin @(negedge clk); t++; end
    chk({tag, " R3 burst completes"}, 32'(t < 4000), 32'd1);
    t = 0;
    while (!req_ready && t < 4000) begin @(negedge clk); t++; end
    chk({tag, " R10 ready returns"}, 32'(t < 4000), 32'd1);
  endtask

  task automatic run_burst(input string tag, input logic [25:0] a, input logic [7:0] n,
                           input logic [3:0] l, input int l_eff, input logic [3:0] g,
                           input logic [3:0] d, input logic p, input logic [31:0] m,
                           input bit b2b);
    int s0, d0, ap0, rb0;
    while (!req_ready) @(negedge clk);
    if (!b2b) repeat (40) @(negedge clk);
    lat = l; gap = g; div = d; pol = p; wait_mask = m; cur_lat = l_eff;
    n_got = 0; s0 = src_idx; d0 = done_cnt; ap0 = adv_push; rb0 = ready_bad;
    issue(a, n);
    wait_end(tag);
    chk({tag, " R1 address"}, 32'(cap_addr), 32'(a));
    chk({tag, " R3 beat count"}, n_got, n);
    for (int j = 0; j < n && j < n_got; j++)
      chk({tag, (j == 0) ? " R2 first beat" : " R3/R4 beat"}, got[j], pat(s0 + j));
    chk({tag, " R9 words fetched"}, src_idx - s0, n);
    chk({tag, " R9 no fetch in address period"}, adv_push - ap0, 0);
    chk({tag, " R10 done pulses"}, done_cnt - d0, 1);
    chk({tag, " R10 ready low at done"}, ready_bad - rb0, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 ce", ce_n, 1); chk("R11 adv", adv_n, 1); chk("R11 we", we_n, 1);
    chk("R11 oe", oe_n, 1); chk("R11 bus drive", ad_oe, 0);
    chk("R11 done", done, 0); chk("R11 ready", req_ready, 1);
  endtask

  task automatic t_basic;
    run_burst("basic", 26'h2A5_1234, 8'd3, 4'd2, 2, 4'd2, 4'd2, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_latency;
    run_burst("latency", 26'h3FF_FFFE, 8'd5, 4'd5, 5, 4'd1, 4'd3, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_wait_high;
    // bit 1 falls in a latency period (R4 ignored); bits 3,5,6 stretch beats
    run_burst("wait_hi", 26'h015_8001, 8'd4, 4'd3, 3, 4'd2, 4'd2, 1'b1,
              32'b110_1010, 1'b0);
  endtask

  task automatic t_wait_low;
    run_burst("wait_lo", 26'h100_0F0F, 8'd3, 4'd2, 2, 4'd3, 4'd4, 1'b0,
              32'b1_0100, 1'b0);
  endtask

  task automatic t_single;
    // lat_i of 1 behaves as 2 (R2)
    run_burst("single", 26'h0AA_5555, 8'd1, 4'd1, 2, 4'd1, 4'd2, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_gap;
    run_burst("gap_a", 26'h001_0000, 8'd2, 4'd2, 2, 4'd5, 4'd4, 1'b1, 32'h0, 1'b0);
    run_burst("gap_b", 26'h001_0002, 8'd2, 4'd2, 2, 4'd5, 4'd4, 1'b1, 32'h0, 1'b1);
    chk("R7 ce high periods >= gap+1", 32'(last_gap >= 6), 32'd1);
  endtask

  task automatic t_div;
    realtime t0, t1, t2;
    while (!req_ready) @(negedge clk);
    div = 4'd5;
    repeat (12) @(negedge clk);
    @(posedge mem_clk); t0 = $realtime;
    @(negedge mem_clk); t1 = $realtime;
    @(posedge mem_clk); t2 = $realtime;
    chk("R8 period cycles", 32'(int'((t2 - t0) / 5.0)), 32'd5);
    chk("R8 high cycles", 32'(int'((t1 - t0) / 5.0)), 32'd3);
    div = 4'd2;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_latency();
    t_wait_high();
    t_wait_low();
    t_single();
    t_gap();
    t_div();
    chk("R5 oe never low", oe_bad, 0);
    chk("R6 bus drive follows ce", bus_bad, 0);
    chk("R1 we low while ce low", we_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule